// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block is the host-side master for a three-wire serial EEPROM. The wires are chip select, serial clock, data toward the memory and data back from it. A one-cycle command strobe starts one of three operations: read a 16-bit word, write a 16-bit word, or release the memory's write protection. The block produces every pin transition itself. Each phase of each transmitted bit is held for a fixed number of system clocks, set by `PHASE_CYC`. That parameter must be at least 4, because the returning data line passes through a two-flop synchronizer. The default of 1000 cycles gives 5 us phases at 200 MHz.

A write is never a single frame. The block first sends an enable frame, then sends the program frame and deselects. It then reselects with the clock idle and polls the returning line until the memory reports ready, and closes with a disable frame. The protection release sends three frames: the plain enable, an arm frame and a clear frame, with the protection line high during the last two. It then polls for ready. A poll that stays low for `POLL_LIMIT` samples ends the operation with the error flag set, and the remaining frames are skipped.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: After reset, chip select, serial clock, data out, drive enable, protection line, busy, done, err and rdata are all 0.
- R2: `cmd_op` encoding: 00 read, 01 write, 10 release protection. 11 is reserved. For a reserved code the block raises done with err=1, leaves chip select low, and leaves rdata unchanged.
- R3: Each transmitted bit has three phases of exactly `PHASE_CYC` clocks each: data valid with the clock low, clock high, clock low. The clock is high for exactly `PHASE_CYC` cycles, and consecutive transmitted bits start `3*PHASE_CYC` cycles apart.
- R4: A read sends 11 bits MSB first: header 1,1,0, then the 8-bit address. It then gives 16 clock pulses and samples the returning line at the end of each high phase, MSB first, into rdata.
- R5: A write sends the enable frame (1,0,0 followed by eight 1s). It then sends a 27-bit frame: header 1,0,1, the address, then the 16 data bits, all MSB first.
- R6: After the program frame the block reselects with the clock low and the drive enable low. It samples the returning line once per `PHASE_CYC` and ends the poll at the first high sample.
- R7: After a successful ready poll, a write sends the disable frame: 1,0,0 followed by eight 0s.
- R8: A protection release sends three frames in order: the enable frame with the protection line low, then 1,0,0 plus eight 1s, then 1,1,1 plus eight 1s. The protection line is high during the last two. A ready poll follows.
- R9: Between consecutive frames of one operation, chip select is low for exactly `PHASE_CYC` cycles.
- R10: If `POLL_LIMIT` consecutive poll samples are low, the poll lasts exactly `POLL_LIMIT*PHASE_CYC` cycles with chip select high. done then comes with err=1, and no further frame is sent.
- R11: busy is high from the cycle after a command is accepted until done. done is a one-cycle pulse with busy low. A strobe while busy is high is ignored.
- R12: rdata changes only while a read is receiving. It holds its value from done until a later read.
- R13: Drive enable is high only while transmitted bits are on the wire, never during receive or polling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_op | input | 2 | Operation code (see R2) |
| cmd_addr | input | 8 | Word address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Ready-poll timeout or reserved code; valid with done |
| rdata | output | 16 | Last word read |
| mw_cs | output | 1 | Chip select to the memory |
| mw_clk | output | 1 | Serial clock to the memory |
| mw_dout | output | 1 | Serial data to the memory |
| mw_drv | output | 1 | Data driver enable, high while bits are sent |
| mw_prot | output | 1 | Protection-register enable line |
| mw_din | input | 1 | Serial data / ready from the memory |

## Verification
A wrong step index or a wrong frame template shows at the pins within one frame. The bit pattern seen on the falling edge of chip select differs from the expected frame, or the frame count of the operation is wrong. A phase counter that is off by one changes the clock-high width or the bit spacing on the very next bit. A bad poll counter shows as a poll window of the wrong length or a missing err at done. A receive shift fault shows as the wrong rdata at the done pulse of the read.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 16;
    localparam int HDR_W      = 3;
    localparam int SHORT_BITS = HDR_W + ADDR_W;
    localparam int LONG_BITS  = SHORT_BITS + DATA_W;
    localparam int CNT_W      = $clog2(LONG_BITS + 1);

    typedef logic [LONG_BITS-1:0] frame_bits_t;

    // Frame headers: start bit followed by the two opcode bits
    localparam logic [HDR_W-1:0] HDR_READ  = 3'b110;
    localparam logic [HDR_W-1:0] HDR_WRITE = 3'b101;
    localparam logic [HDR_W-1:0] HDR_CTRL  = 3'b100;
    localparam logic [HDR_W-1:0] HDR_ERASE = 3'b111;

    typedef enum logic [1:0] {
        OP_READ   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_UNLOCK = 2'b10,
        OP_RSVD   = 2'b11
    } host_op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_TX, S_RX, S_POLL, S_GAP, S_FIN
    } seq_state_e;

    typedef struct packed {
        frame_bits_t      bits;   // left-justified, MSB goes first
        logic [CNT_W-1:0] nbits;
        logic             prot;
        logic             rx;
        logic             poll;
        logic             last;
    } step_t;

    typedef struct packed {
        logic cs;
        logic sk;
        logic dout;
        logic drv;
        logic prot;
    } pins_t;

    function automatic frame_bits_t short_frame(logic [HDR_W-1:0] hdr, logic [ADDR_W-1:0] a);
        return {hdr, a, {DATA_W{1'b0}}};
    endfunction

    // Step program for each operation
    function automatic step_t plan_step(host_op_e op, logic [1:0] idx,
                                        logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        step_t s;
        s       = '0;
        s.nbits = CNT_W'(SHORT_BITS);
        case (op)
            OP_READ: begin
                s.bits = short_frame(HDR_READ, a);
                s.rx   = 1'b1;
                s.last = 1'b1;
            end
            OP_WRITE: begin
                case (idx)
                    2'd0: s.bits = short_frame(HDR_CTRL, {ADDR_W{1'b1}});
                    2'd1: begin
                        s.bits  = {HDR_WRITE, a, d};
                        s.nbits = CNT_W'(LONG_BITS);
                    end
                    2'd2: s.poll = 1'b1;
                    default: begin
                        s.bits = short_frame(HDR_CTRL, {ADDR_W{1'b0}});
                        s.last = 1'b1;
                    end
                endcase
            end
            OP_UNLOCK: begin
                case (idx)
                    2'd0: s.bits = short_frame(HDR_CTRL, {ADDR_W{1'b1}});
                    2'd1: begin
                        s.bits = short_frame(HDR_CTRL, {ADDR_W{1'b1}});
                        s.prot = 1'b1;
                    end
                    2'd2: begin
                        s.bits = short_frame(HDR_ERASE, {ADDR_W{1'b1}});
                        s.prot = 1'b1;
                    end
                    default: begin
                        s.poll = 1'b1;
                        s.last = 1'b1;
                    end
                endcase
            end
            default: s.last = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
    parameter int CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic expire
);
    localparam int W = $clog2(CYC + 1);

    logic [W-1:0] cnt;

    assign expire = !restart && (cnt == W'(CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || restart || expire)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mw_shifter.sv
module mw_shifter
    import mw_eeprom_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  frame_bits_t        load_val,
    input  logic               tx_shift,
    output logic               tx_bit,
    input  logic               rx_shift,
    input  logic               rx_in,
    output logic [DATA_W-1:0]  rx_word
);
    frame_bits_t tx_q;

    assign tx_bit = tx_q[LONG_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q    <= '0;
            rx_word <= '0;
        end else begin
            if (load)
                tx_q <= load_val;
            else if (tx_shift)
                tx_q <= {tx_q[LONG_BITS-2:0], 1'b0};
            if (rx_shift)
                rx_word <= {rx_word[DATA_W-2:0], rx_in};
        end
    end
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
    import mw_eeprom_pkg::*;
#(
    parameter int PHASE_CYC  = 1000,
    parameter int POLL_LIMIT = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [7:0]  cmd_addr,
    input  logic [15:0] cmd_wdata,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [15:0] rdata,
    output logic        mw_cs,
    output logic        mw_clk,
    output logic        mw_dout,
    output logic        mw_drv,
    output logic        mw_prot,
    input  logic        mw_din
);
    localparam int PW = $clog2(POLL_LIMIT + 1);

    seq_state_e          state;
    host_op_e            op_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [1:0]          idx;
    step_t               cur, nxt;
    logic [CNT_W-1:0]    bitcnt;
    logic [1:0]          phase;
    logic [PW-1:0]       poll_cnt;
    logic                err_q, abort_q;
    logic                din_m, din_s;
    pins_t               pins_d, pins_q;
    logic                expire, accept, load, tx_shift, rx_shift, tx_bit, last_bit;

    assign busy   = (state != S_IDLE) && (state != S_FIN);
    assign done   = (state == S_FIN);
    assign err    = err_q;
    assign accept = cmd_valid && !busy;

    assign nxt = accept ? plan_step(host_op_e'(cmd_op), 2'd0, cmd_addr, cmd_wdata)
                        : plan_step(op_q, idx + 2'd1, addr_q, wdata_q);

    assign load     = (accept && host_op_e'(cmd_op) != OP_RSVD) ||
                      (state == S_GAP && expire && !cur.last && !abort_q);
    assign tx_shift = (state == S_TX) && expire && (phase == 2'd2);
    assign rx_shift = (state == S_RX) && expire && (phase == 2'd0);
    assign last_bit = (bitcnt == cur.nbits - CNT_W'(1));

    mw_phase_timer #(.CYC(PHASE_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (state == S_IDLE || state == S_FIN),
        .expire  (expire)
    );

    mw_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (nxt.bits),
        .tx_shift (tx_shift),
        .tx_bit   (tx_bit),
        .rx_shift (rx_shift),
        .rx_in    (din_s),
        .rx_word  (rdata)
    );

    always_comb begin
        pins_d = '0;
        case (state)
            S_TX: begin
                pins_d.cs   = 1'b1;
                pins_d.sk   = (phase == 2'd1);
                pins_d.dout = tx_bit;
                pins_d.drv  = 1'b1;
                pins_d.prot = cur.prot;
            end
            S_RX: begin
                pins_d.cs = 1'b1;
                pins_d.sk = (phase == 2'd0);
            end
            S_POLL:  pins_d.cs = 1'b1;
            default: pins_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            op_q     <= OP_READ;
            addr_q   <= '0;
            wdata_q  <= '0;
            idx      <= '0;
            cur      <= '0;
            bitcnt   <= '0;
            phase    <= '0;
            poll_cnt <= '0;
            err_q    <= 1'b0;
            abort_q  <= 1'b0;
            din_m    <= 1'b0;
            din_s    <= 1'b0;
            pins_q   <= '0;
        end else begin
            din_m  <= mw_din;
            din_s  <= din_m;
            pins_q <= pins_d;
            case (state)
                S_IDLE, S_FIN: begin
                    state <= S_IDLE;
                    if (accept) begin
                        op_q    <= host_op_e'(cmd_op);
                        addr_q  <= cmd_addr;
                        wdata_q <= cmd_wdata;
                        abort_q <= 1'b0;
                        err_q   <= (host_op_e'(cmd_op) == OP_RSVD);
                        if (host_op_e'(cmd_op) == OP_RSVD) begin
                            state <= S_FIN;
                        end else begin
                            cur      <= nxt;
                            idx      <= '0;
                            bitcnt   <= '0;
                            phase    <= '0;
                            poll_cnt <= '0;
                            state    <= S_TX;
                        end
                    end
                end
                S_TX: if (expire) begin
                    if (phase == 2'd2) begin
                        phase <= '0;
                        if (last_bit) begin
                            bitcnt <= '0;
                            state  <= cur.rx ? S_RX : S_GAP;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                S_RX: if (expire) begin
                    if (phase == 2'd0) begin
                        phase <= 2'd1;
                    end else begin
                        phase  <= '0;
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == CNT_W'(DATA_W - 1))
                            state <= S_GAP;
                    end
                end
                S_POLL: if (expire) begin
                    if (din_s) begin
                        state <= S_GAP;
                    end else if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
                        err_q   <= 1'b1;
                        abort_q <= 1'b1;
                        state   <= S_GAP;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                S_GAP: if (expire) begin
                    if (cur.last || abort_q) begin
                        state <= S_FIN;
                    end else begin
                        cur      <= nxt;
                        idx      <= idx + 2'd1;
                        bitcnt   <= '0;
                        phase    <= '0;
                        poll_cnt <= '0;
                        state    <= nxt.poll ? S_POLL : S_TX;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign mw_cs   = pins_q.cs;
    assign mw_clk  = pins_q.sk;
    assign mw_dout = pins_q.dout;
    assign mw_drv  = pins_q.drv;
    assign mw_prot = pins_q.prot;
endmodule

// File: rtl/mw_eeprom_ctrl_chk.sv
module mw_eeprom_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic        busy,
    input logic        done,
    input logic [15:0] rdata,
    input logic        mw_cs,
    input logic        mw_clk,
    input logic        mw_dout,
    input logic        mw_drv,
    input logic        mw_prot
);
    p_done_not_busy_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_fall_done_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cmd_valid) |=> $stable(rdata));

    p_clk_needs_cs_r3: assert property (@(posedge clk) disable iff (rst)
        mw_clk |-> mw_cs);

    p_dout_stable_hi_r3: assert property (@(posedge clk) disable iff (rst)
        (mw_clk && $past(mw_clk)) |-> $stable(mw_dout));

    p_prot_framed_r8: assert property (@(posedge clk) disable iff (rst)
        mw_prot |-> (mw_cs && mw_drv));

    p_drv_framed_r13: assert property (@(posedge clk) disable iff (rst)
        mw_drv |-> mw_cs);
endmodule

bind mw_eeprom_ctrl mw_eeprom_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .rdata     (rdata),
    .mw_cs     (mw_cs),
    .mw_clk    (mw_clk),
    .mw_dout   (mw_dout),
    .mw_drv    (mw_drv),
    .mw_prot   (mw_prot)
);

// File: tb/mw_eeprom_ctrl_tb.sv
`timescale 1ns/1ps
module mw_eeprom_ctrl_tb;
    localparam int P      = 6;
    localparam int PL     = 12;
    localparam int BUSY_T = 30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [7:0]  cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic        busy, done, err;
    logic [15:0] rdata;
    logic        mw_cs, mw_clk, mw_dout, mw_drv, mw_prot;
    logic        mw_din = 1'b1;

    always #2.5 clk = ~clk;

    mw_eeprom_ctrl #(.PHASE_CYC(P), .POLL_LIMIT(PL)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .err(err), .rdata(rdata), .mw_cs(mw_cs), .mw_clk(mw_clk),
        .mw_dout(mw_dout), .mw_drv(mw_drv), .mw_prot(mw_prot), .mw_din(mw_din)
    );

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] init_word(logic [7:0] a);
        return {a, a ^ 8'hC3};
    endfunction

    // ---------------- memory model observing the pins ----------------
    typedef struct { int nb; logic [26:0] bits; bit prot; bit drv; int len; } frm_t;
    frm_t flog[$];

    logic [15:0] mem [256];
    bit wen = 0, locked = 1, armed = 0, stuck = 0;
    int busy_cnt = 0, nb = 0, kout = 0, flen = 0;
    logic [26:0] fr = '0;
    bit fr_prot = 0, fr_drv = 0;
    bit p_cs = 0, p_clk = 0;
    int cyc = 0, hi_w = 0, bad_hi = 0, bad_bit = 0, last_rise = 0;
    bit last_rise_drv = 0;
    int lo_run = 0, bad_gap = 0, done_cnt = 0, fall_seq = -1;

    initial for (int i = 0; i < 256; i++) mem[i] = init_word(8'(i));

    always @(negedge clk) begin
        cyc++;
        if (busy_cnt > 0) busy_cnt--;
        if (mw_clk) hi_w++;
        else if (p_clk) begin
            if (hi_w != P) bad_hi++;
            hi_w = 0;
        end
        if (mw_cs) begin
            if (!p_cs) begin
                if (done_cnt == fall_seq && busy && lo_run != P) bad_gap++;
                nb = 0; fr = '0; fr_prot = 0; fr_drv = 0; kout = 0; flen = 0;
                last_rise_drv = 0;
            end
            flen++;
            if (mw_drv) fr_drv = 1;
            if (mw_clk && !p_clk) begin
                if (mw_drv && last_rise_drv && (cyc - last_rise) != 3*P) bad_bit++;
                last_rise = cyc;
                last_rise_drv = mw_drv;
                if (nb == 11 && fr[10:8] == 3'b110) begin
                    mw_din = mem[fr[7:0]][15-kout];
                    kout++;
                end else begin
                    fr = {fr[25:0], mw_dout};
                    nb++;
                    if (mw_prot) fr_prot = 1;
                end
            end
            if (!(nb == 11 && fr[10:8] == 3'b110))
                mw_din = !stuck && (busy_cnt == 0);
        end else begin
            if (p_cs) begin
                if (nb == 11) begin
                    if (fr[10:8] == 3'b100 && fr[7:0] == 8'hFF && !fr_prot) wen = 1;
                    if (fr[10:8] == 3'b100 && fr[7:0] == 8'h00) wen = 0;
                    if (fr[10:8] == 3'b100 && fr[7:0] == 8'hFF && fr_prot) armed = 1;
                    if (fr[10:8] == 3'b111 && fr[7:0] == 8'hFF && fr_prot && armed && wen) begin
                        locked = 0; armed = 0; busy_cnt = BUSY_T;
                    end
                end
                if (nb == 27 && fr[26:24] == 3'b101) begin
                    if (wen && !locked) mem[fr[23:16]] = fr[15:0];
                    busy_cnt = BUSY_T;
                end
                flog.push_back('{nb, fr, fr_prot, fr_drv, flen});
                fall_seq = done_cnt;
                lo_run = 0;
            end
            lo_run++;
            mw_din = !stuck && (busy_cnt == 0);
        end
        p_cs = mw_cs;
        p_clk = mw_clk;
    end

    // ---------------- scoreboard ----------------
    typedef struct { bit e; bit chk_rd; logic [15:0] rd; string tag; } exp_t;
    exp_t sb[$];
    logic [15:0] last_rd = '0;

    always @(negedge clk) begin
        if (!rst && done) begin
            done_cnt++;
            if (sb.size() == 0) begin
                check(0, "R11 unexpected done", 1, 0);
            end else begin
                exp_t x;
                x = sb.pop_front();
                check(err == x.e, {x.tag, " err"}, int'(err), int'(x.e));
                if (x.chk_rd) check(rdata == x.rd, {x.tag, " rdata"}, int'(rdata), int'(x.rd));
                check(!busy, {x.tag, " busy low at done R11"}, int'(busy), 0);
            end
        end
    end

    task automatic issue(logic [1:0] op, logic [7:0] a, logic [15:0] d,
                         bit e, bit chk_rd, logic [15:0] rd, string tag);
        int start;
        start = done_cnt;
        flog.delete();
        sb.push_back('{e, chk_rd, rd, tag});
        @(posedge clk); #1;
        cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        @(posedge clk); #1;
        cmd_valid = 0;
        wait (done_cnt == start + 1);
        @(negedge clk);
    endtask

    task automatic chk_frame(int i, int n, logic [26:0] b, bit prot, string tag);
        if (i >= flog.size()) begin
            check(0, {tag, " frame missing"}, flog.size(), i + 1);
        end else begin
            check(flog[i].nb == n, {tag, " frame bits"}, flog[i].nb, n);
            check(flog[i].bits == b, {tag, " frame pattern"}, int'(flog[i].bits), int'(b));
            check(flog[i].prot == prot, {tag, " protection line"}, int'(flog[i].prot), int'(prot));
        end
    endtask

    task automatic chk_write_frames(logic [7:0] a, logic [15:0] d, string tag);
        check(flog.size() == 4, {tag, " R5 frame count"}, flog.size(), 4);
        chk_frame(0, 11, 27'({3'b100, 8'hFF}), 0, {tag, " R5 enable"});
        chk_frame(1, 27, {3'b101, a, d}, 0, {tag, " R5 program"});
        chk_frame(2, 0, 27'd0, 0, {tag, " R6 poll"});
        if (flog.size() > 2)
            check(flog[2].drv == 0, {tag, " R13 drive off in poll"}, int'(flog[2].drv), 0);
        chk_frame(3, 11, 27'({3'b100, 8'h00}), 0, {tag, " R7 disable"});
    endtask

    task automatic do_read(logic [7:0] a, logic [15:0] exp_d, string tag);
        issue(2'b00, a, 16'h0, 0, 1, exp_d, {tag, " R4 read"});
        last_rd = exp_d;
        check(flog.size() == 1, {tag, " R4 single frame"}, flog.size(), 1);
        chk_frame(0, 11, 27'({3'b110, a}), 0, {tag, " R4 header"});
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check(!mw_cs && !mw_clk && !mw_dout && !mw_drv && !mw_prot, "R1 pins idle", int'(mw_cs), 0);
        check(!busy && !done && !err && rdata == 0, "R1 status idle", int'(rdata), 0);

        do_read(8'h3C, init_word(8'h3C), "t1");
        do_read(8'h00, init_word(8'h00), "t2");

        // write while protected: frames sent, contents unchanged
        issue(2'b01, 8'h12, 16'hBEEF, 0, 1, last_rd, "t3 R5 write locked");
        chk_write_frames(8'h12, 16'hBEEF, "t3");
        do_read(8'h12, init_word(8'h12), "t3 R8 still protected");

        issue(2'b10, 8'h00, 16'h0, 0, 1, last_rd, "t4 R8 release");
        check(flog.size() == 4, "t4 R8 frame count", flog.size(), 4);
        chk_frame(0, 11, 27'({3'b100, 8'hFF}), 0, "t4 R8 enable");
        chk_frame(1, 11, 27'({3'b100, 8'hFF}), 1, "t4 R8 arm");
        chk_frame(2, 11, 27'({3'b111, 8'hFF}), 1, "t4 R8 clear");
        chk_frame(3, 0, 27'd0, 0, "t4 R8 poll");

        issue(2'b01, 8'h12, 16'hBEEF, 0, 1, last_rd, "t5 R5 write");
        chk_write_frames(8'h12, 16'hBEEF, "t5");
        if (flog.size() > 2)
            check(flog[2].len > 0 && flog[2].len < PL*P, "t5 R6 poll ended on ready", flog[2].len, PL*P);
        issue(2'b01, 8'hFF, 16'h8000, 0, 1, last_rd, "t6 R5 write top");
        chk_write_frames(8'hFF, 16'h8000, "t6");
        issue(2'b01, 8'hA5, 16'h0001, 0, 1, last_rd, "t7 R5 write lsb");
        do_read(8'hFF, 16'h8000, "t8");
        do_read(8'hA5, 16'h0001, "t9");
        do_read(8'h12, 16'hBEEF, "t10");

        // R12: rdata holds through idle time and a write
        repeat (100) @(negedge clk);
        check(rdata == 16'hBEEF, "R12 rdata hold idle", int'(rdata), 16'hBEEF);
        issue(2'b01, 8'h55, 16'h1234, 0, 1, 16'hBEEF, "t11 R12 rdata across write");

        // R11: strobe during busy is ignored
        begin
            int start;
            start = done_cnt;
            flog.delete();
            sb.push_back('{0, 1, init_word(8'h77), "t12 R11 read"});
            @(posedge clk); #1;
            cmd_valid = 1; cmd_op = 2'b00; cmd_addr = 8'h77;
            @(posedge clk); #1;
            cmd_valid = 0;
            repeat (20) @(posedge clk);
            #1 cmd_valid = 1; cmd_op = 2'b01; cmd_addr = 8'h01; cmd_wdata = 16'hDEAD;
            @(posedge clk); #1 cmd_valid = 0;
            wait (done_cnt == start + 1);
            repeat (200) @(negedge clk);
            check(done_cnt == start + 1, "R11 ignored strobe gives no done", done_cnt, start + 1);
            check(flog.size() == 1, "R11 ignored strobe sends no frame", flog.size(), 1);
            last_rd = init_word(8'h77);
        end

        // R2: reserved code
        issue(2'b11, 8'h10, 16'h0, 1, 1, last_rd, "t13 R2 reserved");
        check(flog.size() == 0, "R2 reserved no select", flog.size(), 0);

        // R10: ready never comes
        stuck = 1;
        issue(2'b01, 8'h40, 16'h4321, 1, 1, last_rd, "t14 R10 timeout");
        check(flog.size() == 3, "R10 no disable frame after timeout", flog.size(), 3);
        if (flog.size() > 2)
            check(flog[2].nb == 0 && flog[2].len == PL*P, "R10 poll window", flog[2].len, PL*P);
        stuck = 0;
        issue(2'b01, 8'h41, 16'h0F0F, 0, 1, last_rd, "t15 R10 recovery");

        check(bad_hi == 0, "R3 clock high width", bad_hi, 0);
        check(bad_bit == 0, "R3 bit spacing", bad_bit, 0);
        check(bad_gap == 0, "R9 deselect gap", bad_gap, 0);
        check(sb.size() == 0, "R11 all commands completed", sb.size(), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule